// File: doc/BRIEF.md
# Serial Slave Byte Receiver with Low-Level Request

This block takes bytes that a host shifts in over a three-wire synchronous link (a bit clock, a framing strobe and a data line) and parks them in a deep on-chip queue. The internal controller pops the queue at its own pace. While the queue holds few bytes, an active-low request output tells the host to send more, so the host can push data in bursts.

All three link inputs are oversampled by the system clock through synchroniser chains. Rising edges of the bit clock and of the framing strobe are detected from the synchronised copies, so the system clock must run at least four times faster than the bit clock. A two-state machine frames the bits. After reset it sits in `ST_HUNT` and ignores the link. A strobe rising edge takes it to `ST_SHIFT` (transition ALIGN). In `ST_SHIFT`, every eighth sampled bit completes a byte (transition BYTE_DONE, back into `ST_SHIFT`). A further strobe rising edge clears any partial byte (transition REALIGN, also back into `ST_SHIFT`). Later bytes need no new strobe.

The queue raises a sticky overflow flag when a byte arrives while it is full, and drops that byte. The read port has a registered data output and an empty flag.

Top module: `ssr_top`

## Requirements
- R1: Bits are sampled on rising edges of `sclk_i` and assembled most significant bit first.
- R2: After reset, no byte is stored until the first rising edge of `sync_i` has been seen.
- R3: A rising edge of `sync_i` partway through a byte discards the bits gathered so far. The next sampled bit becomes the most significant bit of a new byte.
- R4: Once aligned, each group of 8 sampled bits forms one byte, with no further `sync_i` edge needed.
- R5: Bytes leave the queue in arrival order, and up to DEPTH (256) bytes are held.
- R6: `more_n` is 0 while the stored count is below LOW_MARK (64), and 1 otherwise.
- R7: A byte completed while the queue holds DEPTH bytes is dropped and sets `ovf` to 1. `ovf` stays at 1 until it is cleared.
- R8: A cycle with `ovf_clr` high clears `ovf`. If a new drop happens in the same cycle, the set wins.
- R9: A cycle with `rd_en` high while `empty` is 0 removes the oldest byte. That byte appears on `rd_data` from the next cycle, and `empty` is 1 exactly when the count is 0.
- R10: `rd_en` while `empty` is 1 has no effect: `rd_data` keeps its value and no later byte is lost.
- R11: After reset, `empty` is 1, `ovf` is 0, `more_n` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host bit clock |
| sync_i | input | 1 | Host framing strobe; its rising edge aligns a byte |
| sdin_i | input | 1 | Host serial data |
| rd_en | input | 1 | Pop one byte |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 8 | Last popped byte, registered |
| empty | output | 1 | Queue holds no byte |
| ovf | output | 1 | Sticky flag: a byte was dropped |
| more_n | output | 1 | Low while the fill level is under the low mark |

## Verification
The hardest case to reach from the ports is the full-queue drop. To get there, the bench streams 256 bytes through the serial link with nothing popped, using random data and random re-alignment strobes. It then shifts in one more byte and drains the whole queue. This shows that the extra byte never entered, that order held, and that the flag stayed set until cleared. The mid-byte re-alignment is reached by stopping the bit clock after three bits and raising the strobe.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_SHIFT = 1'b1
    } frm_state_t;
endpackage

// File: rtl/ssr_sampler.sv
module ssr_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sync_i,
    input  logic sdin_i,
    output logic sclk_rise,
    output logic sync_rise,
    output logic sdin_s
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] chain [STAGES];
    logic [1:0]      prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= '0;
            end else if (g == 0) begin
                chain[g] <= {sdin_i, sync_i, sclk_i};
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1][1:0];
    end

    assign sclk_rise = chain[STAGES-1][0] & ~prev_q[0];
    assign sync_rise = chain[STAGES-1][1] & ~prev_q[1];
    assign sdin_s    = chain[STAGES-1][2];
endmodule

// File: rtl/ssr_framer.sv
module ssr_framer
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sync_rise,
    input  logic             sdin_s,
    output logic [WIDTH-1:0] byte_data,
    output logic             byte_vld
);
    localparam int CW = $clog2(WIDTH);

    frm_state_t       st_q, st_d;
    logic [CW-1:0]    bit_cnt;
    logic [WIDTH-1:0] shreg;

    // next-state logic: ALIGN, REALIGN, BYTE_DONE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:  if (sync_rise) st_d = ST_SHIFT;
            ST_SHIFT: st_d = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_data <= '0;
            byte_vld  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (sync_rise) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (st_q == ST_SHIFT && sclk_rise) begin
                shreg <= {shreg[WIDTH-2:0], sdin_s};
                if (bit_cnt == CW'(WIDTH-1)) begin
                    byte_data <= {shreg[WIDTH-2:0], sdin_s};
                    byte_vld  <= 1'b1;
                    bit_cnt   <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT) |-> !byte_vld);
    // R4
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(sclk_rise) && !$past(sync_rise));
endmodule

// File: rtl/ssr_fifo.sv
module ssr_fifo #(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 256,
    parameter int LOW_MARK = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             ovf,
    output logic             more_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             wr_ok, rd_ok, drop;

    assign wr_ok = wr_vld && (cnt != CW'(DEPTH));
    assign drop  = wr_vld && (cnt == CW'(DEPTH));
    assign rd_ok = rd_en && (cnt != '0);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            rd_data <= '0;
            ovf     <= 1'b0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) begin
                rd_data <= mem[rptr];
                rptr    <= rptr + 1'b1;
            end
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign empty  = (cnt == '0);
    assign more_n = (cnt >= CW'(LOW_MARK));

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf) && !$past(ovf_clr) |-> ovf);
    // R9
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !empty && !wr_vld |=> cnt == $past(cnt) - 1'b1);
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && empty && !wr_vld |=> $stable(rd_data) && empty);
endmodule

// File: rtl/ssr_top.sv
module ssr_top #(
    parameter int WIDTH       = 8,
    parameter int DEPTH       = 256,
    parameter int LOW_MARK    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sync_i,
    input  logic             sdin_i,
    input  logic             rd_en,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             ovf,
    output logic             more_n
);
    logic             sclk_rise, sync_rise, sdin_s;
    logic [WIDTH-1:0] byte_data;
    logic             byte_vld;

    ssr_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk_i), .sync_i(sync_i), .sdin_i(sdin_i),
        .sclk_rise(sclk_rise), .sync_rise(sync_rise), .sdin_s(sdin_s)
    );

    ssr_framer #(.WIDTH(WIDTH)) u_framer (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sync_rise(sync_rise), .sdin_s(sdin_s),
        .byte_data(byte_data), .byte_vld(byte_vld)
    );

    ssr_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(byte_vld), .wr_data(byte_data),
        .rd_en(rd_en), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .empty(empty), .ovf(ovf), .more_n(more_n)
    );
endmodule

// File: tb/ssr_top_bench.sv
module ssr_top_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       sclk_i = 0, sync_i = 0, sdin_i = 0, rd_en = 0, ovf_clr = 0;
    logic [7:0] rd_data;
    logic       empty, ovf, more_n;
    int         tests = 0, fails = 0;
    logic [7:0] model [$];

    always #4 clk = ~clk;

    ssr_top u_ssr_top (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sync_i(sync_i),
        .sdin_i(sdin_i), .rd_en(rd_en), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .empty(empty), .ovf(ovf), .more_n(more_n)
    );

    function automatic logic exp_more_n(int n);
        return (n >= 64);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        sclk_i = 0; sdin_i = b;
        repeat (2) @(negedge clk);
        sclk_i = 1;
        repeat (2) @(negedge clk);
        sclk_i = 0;
    endtask

    task automatic strobe();
        sclk_i = 0; sync_i = 0;
        repeat (2) @(negedge clk);
        sync_i = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] b, bit with_sync, bit keep);
        if (with_sync) strobe();
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i]);
            sync_i = 0;
        end
        repeat (12) @(negedge clk);
        if (keep && model.size() < 256) model.push_back(b);
    endtask

    task automatic pop_check(string req);
        logic [7:0] e;
        @(negedge clk) rd_en = 1;
        @(negedge clk) rd_en = 0;
        e = model.pop_front();
        check(rd_data == e, req, rd_data, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check(empty == 1, "R11 empty", empty, 1);
        check(ovf == 0, "R11 ovf", ovf, 0);
        check(more_n == 0, "R11 more_n", more_n, 0);
        check(rd_data == 0, "R11 rd_data", rd_data, 0);

        // R2 bits before any strobe are ignored
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        repeat (12) @(negedge clk);
        check(empty == 1, "R2 unaligned bits ignored", empty, 1);

        // R1 bit order, R4 continuous framing
        send_byte(8'h80, 1, 1);
        send_byte(8'h01, 0, 1);
        send_byte(8'hA5, 0, 1);
        for (int i = 0; i < 4; i++) send_byte(8'($urandom), 0, 1);
        pop_check("R1 msb first");
        pop_check("R1 lsb last");
        for (int i = 0; i < 5; i++) pop_check("R4 continuous bytes");
        check(empty == 1, "R9 empty after drain", empty, 1);

        // R3 mid-byte re-alignment
        strobe(); sync_i = 0;
        send_bit(1); send_bit(0); send_bit(1);
        send_byte(8'h3C, 1, 1);
        pop_check("R3 partial discarded");
        check(empty == 1, "R3 single byte only", empty, 1);

        // R10 pop on empty has no effect
        held = rd_data;
        @(negedge clk) rd_en = 1;
        @(negedge clk) rd_en = 0;
        check(rd_data == held, "R10 rd_data kept", rd_data, held);
        check(empty == 1, "R10 still empty", empty, 1);
        send_byte(8'hC3, 0, 1);
        check(empty == 0, "R9 empty low with data", empty, 0);
        pop_check("R10 next byte intact");

        // R6 watermark boundary
        for (int i = 0; i < 63; i++) send_byte(8'($urandom), ($urandom % 5) == 0, 1);
        check(more_n == exp_more_n(63), "R6 count 63", more_n, exp_more_n(63));
        send_byte(8'($urandom), 0, 1);
        check(more_n == exp_more_n(64), "R6 count 64", more_n, exp_more_n(64));
        pop_check("R5 order at mark");
        check(more_n == exp_more_n(63), "R6 back to 63", more_n, exp_more_n(63));

        // R7 fill and overflow
        while (model.size() < 256) send_byte(8'($urandom), ($urandom % 7) == 0, 1);
        check(ovf == 0, "R7 no drop at full", ovf, 0);
        send_byte(8'hEE, 0, 0);
        check(ovf == 1, "R7 drop sets flag", ovf, 1);
        for (int i = 0; i < 256; i++) pop_check("R5 order through full queue");
        check(empty == 1, "R7 dropped byte absent", empty, 1);
        check(ovf == 1, "R7 flag sticky", ovf, 1);

        // R8 clear
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        check(ovf == 0, "R8 clear", ovf, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule